// File: doc/BRIEF.md
# Rolling Shutter Row Sequencer

This block drives the row side of a rolling-shutter pixel array whose columns carry four readout channels, so four rows are converted in every line time. It keeps a line counter that divides each line into clock counts, and two row-group pointers: a read pointer that walks the programmed window one group of four rows per line, and a shutter pointer that runs a programmable number of groups ahead of it and clears pixels to start their exposure. The array is split into an upper and a lower half that are read at the same time, so every pointer is presented as a pair of group addresses, one for each half.

Inside each line the sequencer raises row select, reset and transfer strobes on all four rows of the read group, two one-cycle sample phases for the column circuits, and a combined reset/transfer strobe on the shutter group. Every edge sits at a programmable line count. Frame rate follows from the clock frequency, the line length in clocks and the window height in groups. The window also carries column bounds, which are passed to the column side. All settings are captured into an active copy at start and again at each frame boundary, so a frame is always scanned with one consistent setting.

Top module: `rs_row_sequencer`

## Requirements
- R1: While reset is high, and after it until the first start, `running`, `line_start`, `frame_start`, all row and shutter strobes, both sample phases, `col_first` and `col_last` are 0.
- R2: A one-cycle `start` while idle makes `running` 1 on the next cycle; in that cycle the line count is 0 and the first group of the window is addressed. `start` while running has no effect on any output.
- R3: With a line length L of at least 2 (`cfg_line_len`), `line_start` is high for exactly one cycle at line count 0, once every L cycles.
- R4: `rd_grp_top` equals the window's first group plus the read index; the index rises by one at each line end and, after the window's last group, returns to 0. `frame_start` is high in the line-count-0 cycle of index 0 only.
- R5: `rd_grp_bot` and `sh_grp_bot` equal the matching upper-half address plus 2^(GRP_W-1) (128 by default).
- R6: The shutter index is (read index + e) mod H, with H the window height in groups and e = min(`cfg_expo`, H); `sh_grp_top` is the window's first group plus that index.
- R7: On all four lanes together, `rd_sel` is high for line counts in [sel_on, sel_off), `rd_rst` in [rst_on, rst_off) and `rd_tx` in [tx_on, tx_off).
- R8: `samp_rst` is high only at line count `cfg_t_samp_rst`, `samp_sig` only at line count `cfg_t_samp_sig`, each while running.
- R9: `sh_rst` and `sh_tx` are high on all four lanes for line counts in [shut_on, shut_off) when e is not 0, and never when e is 0.
- R10: Configuration inputs changed during a frame have no effect on any output until the first cycle of the next frame, where they all take effect together.
- R11: `col_first` and `col_last` show the column bounds of the active configuration.
- R12: A window whose last group is below its first is scanned as the single group at its first group, so every line starts a frame.

Ports follow; HGRP_W = GRP_W-1, LINE_W = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin scanning (pulse, honoured while idle) |
| cfg_line_len | input | LINE_W | Line time in clocks |
| cfg_win_first | input | HGRP_W (7) | First row group of the window, per half |
| cfg_win_last | input | HGRP_W (7) | Last row group of the window, per half |
| cfg_expo | input | HGRP_W (7) | Shutter lead in row groups |
| cfg_col_first | input | COL_W (11) | First column of the window |
| cfg_col_last | input | COL_W (11) | Last column of the window |
| cfg_t_sel_on | input | LINE_W | Line count where row select rises |
| cfg_t_rst_on | input | LINE_W | Line count where row reset rises |
| cfg_t_rst_off | input | LINE_W | Line count where row reset falls |
| cfg_t_samp_rst | input | LINE_W | Line count of the reset-level sample |
| cfg_t_tx_on | input | LINE_W | Line count where transfer rises |
| cfg_t_tx_off | input | LINE_W | Line count where transfer falls |
| cfg_t_samp_sig | input | LINE_W | Line count of the signal-level sample |
| cfg_t_sel_off | input | LINE_W | Line count where row select falls |
| cfg_t_shut_on | input | LINE_W | Line count where the shutter strobe rises |
| cfg_t_shut_off | input | LINE_W | Line count where the shutter strobe falls |
| running | output | 1 | Sequencer active |
| line_start | output | 1 | First cycle of a line |
| frame_start | output | 1 | First cycle of a frame |
| rd_grp_top | output | GRP_W (8) | Read group address, upper half |
| rd_grp_bot | output | GRP_W (8) | Read group address, lower half |
| sh_grp_top | output | GRP_W (8) | Shutter group address, upper half |
| sh_grp_bot | output | GRP_W (8) | Shutter group address, lower half |
| rd_sel | output | LANES (4) | Row select per row of the read group |
| rd_rst | output | LANES (4) | Pixel reset per row of the read group |
| rd_tx | output | LANES (4) | Charge transfer per row of the read group |
| sh_rst | output | LANES (4) | Pixel reset per row of the shutter group |
| sh_tx | output | LANES (4) | Charge transfer per row of the shutter group |
| samp_rst | output | 1 | Column sample phase, reset level |
| samp_sig | output | 1 | Column sample phase, signal level |
| col_first | output | COL_W (11) | Active first column |
| col_last | output | COL_W (11) | Active last column |

## Verification
A four-group window with a two-group shutter lead over two full frames separates correct read-index wrap from off-by-one wrap, and shows the shutter pointer leading modulo the height. A mid-frame change to a shorter line, a three-group window, new columns and an oversized lead tells immediate loading apart from frame-boundary loading and exercises the clamp, which puts the shutter on the read group. A zero lead shows the shutter strobes fully suppressed, an inverted window shows the one-group fallback with a frame marker on every line, and a start pulse mid-frame shows that the scan is not restarted.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int LINE_W = 16;
    localparam int NSPAN  = 4;

    typedef logic [LINE_W-1:0] line_cnt_t;

    // Edge positions inside one line, in line-counter counts
    typedef struct packed {
        line_cnt_t sel_on;
        line_cnt_t rst_on;
        line_cnt_t rst_off;
        line_cnt_t samp_rst;
        line_cnt_t tx_on;
        line_cnt_t tx_off;
        line_cnt_t samp_sig;
        line_cnt_t sel_off;
        line_cnt_t shut_on;
        line_cnt_t shut_off;
    } edge_times_t;

    // Strobe spans decoded from the line counter
    typedef enum logic [1:0] {
        SPAN_SEL  = 2'd0,
        SPAN_RST  = 2'd1,
        SPAN_TX   = 2'd2,
        SPAN_SHUT = 2'd3
    } span_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // Half-open span test: on <= c < off
    function automatic logic in_span(line_cnt_t c, line_cnt_t on, line_cnt_t off);
        return (c >= on) && (c < off);
    endfunction

endpackage

// File: rtl/rsq_line_timer.sv
module rsq_line_timer
    import rsq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      run,
    input  line_cnt_t len,
    output line_cnt_t cnt,
    output logic      line_end
);

    assign line_end = run && (cnt == (len - line_cnt_t'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (line_end) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + line_cnt_t'(1);
        end
    end

endmodule

// File: rtl/rsq_row_pointer.sv
module rsq_row_pointer #(
    parameter int HGRP_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              line_end,
    input  logic [HGRP_W-1:0] win_span,
    input  logic [HGRP_W-1:0] expo,
    output logic [HGRP_W-1:0] rd_idx,
    output logic [HGRP_W-1:0] sh_idx,
    output logic              shut_en,
    output logic              frame_wrap
);

    // Wide enough for index + height without overflow
    localparam int SW = HGRP_W + 2;

    logic [SW-1:0] height;
    logic [SW-1:0] lead;
    logic [SW-1:0] sum;
    logic [SW-1:0] sh_wide;

    assign height  = SW'(win_span) + SW'(1);
    assign lead    = (SW'(expo) > height) ? height : SW'(expo);
    assign shut_en = (lead != '0);
    assign sum     = SW'(rd_idx) + lead;
    assign sh_wide = (sum >= height) ? (sum - height) : sum;
    assign sh_idx  = HGRP_W'(sh_wide);

    assign frame_wrap = line_end && (rd_idx == win_span);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_idx <= '0;
        end else if (restart) begin
            rd_idx <= '0;
        end else if (line_end) begin
            rd_idx <= frame_wrap ? '0 : rd_idx + HGRP_W'(1);
        end
    end

endmodule

// File: rtl/rsq_strobe_decode.sv
module rsq_strobe_decode
    import rsq_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             run,
    input  logic             shut_en,
    input  line_cnt_t        cnt,
    input  edge_times_t      tm,
    output logic [LANES-1:0] sel_o,
    output logic [LANES-1:0] prst_o,
    output logic [LANES-1:0] tx_o,
    output logic [LANES-1:0] shrst_o,
    output logic [LANES-1:0] shtx_o,
    output logic             samp_rst_o,
    output logic             samp_sig_o
);

    line_cnt_t        on_v  [NSPAN];
    line_cnt_t        off_v [NSPAN];
    logic [NSPAN-1:0] hit;

    assign on_v[SPAN_SEL]   = tm.sel_on;
    assign off_v[SPAN_SEL]  = tm.sel_off;
    assign on_v[SPAN_RST]   = tm.rst_on;
    assign off_v[SPAN_RST]  = tm.rst_off;
    assign on_v[SPAN_TX]    = tm.tx_on;
    assign off_v[SPAN_TX]   = tm.tx_off;
    assign on_v[SPAN_SHUT]  = tm.shut_on;
    assign off_v[SPAN_SHUT] = tm.shut_off;

    for (genvar s = 0; s < NSPAN; s++) begin : g_span
        assign hit[s] = run && in_span(cnt, on_v[s], off_v[s]);
    end

    // Each row of the group feeds its own column channel: same timing on every lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign sel_o[l]   = hit[SPAN_SEL];
        assign prst_o[l]  = hit[SPAN_RST];
        assign tx_o[l]    = hit[SPAN_TX];
        assign shrst_o[l] = hit[SPAN_SHUT] && shut_en;
        assign shtx_o[l]  = hit[SPAN_SHUT] && shut_en;
    end

    assign samp_rst_o = run && (cnt == tm.samp_rst);
    assign samp_sig_o = run && (cnt == tm.samp_sig);

endmodule

// File: rtl/rs_row_sequencer.sv
module rs_row_sequencer
    import rsq_pkg::*;
#(
    parameter int GRP_W = 8,
    parameter int COL_W = 11,
    parameter int LANES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [LINE_W-1:0]   cfg_line_len,
    input  logic [GRP_W-2:0]    cfg_win_first,
    input  logic [GRP_W-2:0]    cfg_win_last,
    input  logic [GRP_W-2:0]    cfg_expo,
    input  logic [COL_W-1:0]    cfg_col_first,
    input  logic [COL_W-1:0]    cfg_col_last,
    input  logic [LINE_W-1:0]   cfg_t_sel_on,
    input  logic [LINE_W-1:0]   cfg_t_rst_on,
    input  logic [LINE_W-1:0]   cfg_t_rst_off,
    input  logic [LINE_W-1:0]   cfg_t_samp_rst,
    input  logic [LINE_W-1:0]   cfg_t_tx_on,
    input  logic [LINE_W-1:0]   cfg_t_tx_off,
    input  logic [LINE_W-1:0]   cfg_t_samp_sig,
    input  logic [LINE_W-1:0]   cfg_t_sel_off,
    input  logic [LINE_W-1:0]   cfg_t_shut_on,
    input  logic [LINE_W-1:0]   cfg_t_shut_off,
    output logic                running,
    output logic                line_start,
    output logic                frame_start,
    output logic [GRP_W-1:0]    rd_grp_top,
    output logic [GRP_W-1:0]    rd_grp_bot,
    output logic [GRP_W-1:0]    sh_grp_top,
    output logic [GRP_W-1:0]    sh_grp_bot,
    output logic [LANES-1:0]    rd_sel,
    output logic [LANES-1:0]    rd_rst,
    output logic [LANES-1:0]    rd_tx,
    output logic [LANES-1:0]    sh_rst,
    output logic [LANES-1:0]    sh_tx,
    output logic                samp_rst,
    output logic                samp_sig,
    output logic [COL_W-1:0]    col_first,
    output logic [COL_W-1:0]    col_last
);

    localparam int HGRP_W = GRP_W - 1;
    localparam logic [GRP_W-1:0] HALF_OFS = GRP_W'(1) << HGRP_W;

    seq_state_e        state;
    edge_times_t       cfg_times;
    edge_times_t       act_times;
    line_cnt_t         act_len;
    logic [HGRP_W-1:0] act_first;
    logic [HGRP_W-1:0] act_span;
    logic [HGRP_W-1:0] act_expo;
    logic [COL_W-1:0]  act_col_first;
    logic [COL_W-1:0]  act_col_last;
    logic [HGRP_W-1:0] cfg_span;

    logic              restart;
    logic              load;
    logic              run;
    line_cnt_t         cnt;
    logic              line_end;
    logic [HGRP_W-1:0] rd_idx;
    logic [HGRP_W-1:0] sh_idx;
    logic              shut_en;
    logic              frame_wrap;

    assign cfg_times = '{
        sel_on:   cfg_t_sel_on,
        rst_on:   cfg_t_rst_on,
        rst_off:  cfg_t_rst_off,
        samp_rst: cfg_t_samp_rst,
        tx_on:    cfg_t_tx_on,
        tx_off:   cfg_t_tx_off,
        samp_sig: cfg_t_samp_sig,
        sel_off:  cfg_t_sel_off,
        shut_on:  cfg_t_shut_on,
        shut_off: cfg_t_shut_off
    };

    // An inverted window collapses to one group at its first bound
    assign cfg_span = (cfg_win_last < cfg_win_first) ? '0 : (cfg_win_last - cfg_win_first);

    assign run     = (state == SEQ_RUN);
    assign restart = (state == SEQ_IDLE) && start;
    assign load    = restart || frame_wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
        end else if (restart) begin
            state <= SEQ_RUN;
        end
    end

    // Active (shadow) configuration, refreshed only at frame boundaries
    always_ff @(posedge clk) begin
        if (rst) begin
            act_times     <= '0;
            act_len       <= '0;
            act_first     <= '0;
            act_span      <= '0;
            act_expo      <= '0;
            act_col_first <= '0;
            act_col_last  <= '0;
        end else if (load) begin
            act_times     <= cfg_times;
            act_len       <= cfg_line_len;
            act_first     <= cfg_win_first;
            act_span      <= cfg_span;
            act_expo      <= cfg_expo;
            act_col_first <= cfg_col_first;
            act_col_last  <= cfg_col_last;
        end
    end

    rsq_line_timer i_timer (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .run      (run),
        .len      (act_len),
        .cnt      (cnt),
        .line_end (line_end)
    );

    rsq_row_pointer #(
        .HGRP_W (HGRP_W)
    ) i_ptr (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .line_end   (line_end),
        .win_span   (act_span),
        .expo       (act_expo),
        .rd_idx     (rd_idx),
        .sh_idx     (sh_idx),
        .shut_en    (shut_en),
        .frame_wrap (frame_wrap)
    );

    rsq_strobe_decode #(
        .LANES (LANES)
    ) i_dec (
        .run        (run),
        .shut_en    (shut_en),
        .cnt        (cnt),
        .tm         (act_times),
        .sel_o      (rd_sel),
        .prst_o     (rd_rst),
        .tx_o       (rd_tx),
        .shrst_o    (sh_rst),
        .shtx_o     (sh_tx),
        .samp_rst_o (samp_rst),
        .samp_sig_o (samp_sig)
    );

    assign running     = run;
    assign line_start  = run && (cnt == '0);
    assign frame_start = line_start && (rd_idx == '0);

    assign rd_grp_top = GRP_W'(act_first + rd_idx);
    assign sh_grp_top = GRP_W'(act_first + sh_idx);
    assign rd_grp_bot = rd_grp_top + HALF_OFS;
    assign sh_grp_bot = sh_grp_top + HALF_OFS;

    assign col_first = act_col_first;
    assign col_last  = act_col_last;

endmodule

// File: rtl/rsq_row_sequencer_chk.sv
module rsq_row_sequencer_chk #(
    parameter int GRP_W = 8,
    parameter int COL_W = 11,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             running,
    input logic             line_start,
    input logic             frame_start,
    input logic [LANES-1:0] rd_sel,
    input logic [LANES-1:0] sh_tx,
    input logic [GRP_W-1:0] rd_grp_top,
    input logic [GRP_W-2:0] act_first,
    input logic [GRP_W-2:0] act_span,
    input logic [COL_W-1:0] col_first
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !running |-> (rd_sel == '0 && sh_tx == '0 && !line_start && !frame_start)); // R1

    AST_START_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!running && start) |=> (running && frame_start)); // R2

    AST_LINE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start); // R3

    AST_FRAME_IN_LINE: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start); // R4

    AST_READ_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        running |-> (rd_grp_top >= GRP_W'(act_first)
                     && rd_grp_top <= GRP_W'(act_first) + GRP_W'(act_span))); // R4

    AST_LANES_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        (rd_sel != '0) |-> ($countones(rd_sel) == LANES)); // R7

    AST_COLS_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        (running && !$stable(col_first)) |-> frame_start); // R10

endmodule

bind rs_row_sequencer rsq_row_sequencer_chk #(
    .GRP_W (GRP_W),
    .COL_W (COL_W),
    .LANES (LANES)
) i_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .running     (running),
    .line_start  (line_start),
    .frame_start (frame_start),
    .rd_sel      (rd_sel),
    .sh_tx       (sh_tx),
    .rd_grp_top  (rd_grp_top),
    .act_first   (act_first),
    .act_span    (act_span),
    .col_first   (col_first)
);

// File: tb/test_rs_row_sequencer.sv
module test_rs_row_sequencer;

    localparam int GRP_W = 8;
    localparam int COL_W = 11;
    localparam int LANES = 4;
    localparam int LW    = 16;
    localparam int HW    = GRP_W - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [LW-1:0]    c_len = '0;
    logic [HW-1:0]    c_first = '0, c_last = '0, c_expo = '0;
    logic [COL_W-1:0] c_cf = '0, c_cl = '0;
    logic [LW-1:0]    t_sel_on = '0, t_rst_on = '0, t_rst_off = '0, t_srst = '0, t_tx_on = '0;
    logic [LW-1:0]    t_tx_off = '0, t_ssig = '0, t_sel_off = '0, t_sh_on = '0, t_sh_off = '0;

    logic running, line_start, frame_start, samp_rst, samp_sig;
    logic [GRP_W-1:0] rd_grp_top, rd_grp_bot, sh_grp_top, sh_grp_bot;
    logic [LANES-1:0] rd_sel, rd_rst, rd_tx, sh_rst, sh_tx;
    logic [COL_W-1:0] col_first, col_last;

    int n_tot = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rs_row_sequencer #(.GRP_W(GRP_W), .COL_W(COL_W), .LANES(LANES)) i_rs_row_sequencer (
        .clk(clk), .rst(rst), .start(start),
        .cfg_line_len(c_len), .cfg_win_first(c_first), .cfg_win_last(c_last), .cfg_expo(c_expo),
        .cfg_col_first(c_cf), .cfg_col_last(c_cl),
        .cfg_t_sel_on(t_sel_on), .cfg_t_rst_on(t_rst_on), .cfg_t_rst_off(t_rst_off),
        .cfg_t_samp_rst(t_srst), .cfg_t_tx_on(t_tx_on), .cfg_t_tx_off(t_tx_off),
        .cfg_t_samp_sig(t_ssig), .cfg_t_sel_off(t_sel_off),
        .cfg_t_shut_on(t_sh_on), .cfg_t_shut_off(t_sh_off),
        .running(running), .line_start(line_start), .frame_start(frame_start),
        .rd_grp_top(rd_grp_top), .rd_grp_bot(rd_grp_bot),
        .sh_grp_top(sh_grp_top), .sh_grp_bot(sh_grp_bot),
        .rd_sel(rd_sel), .rd_rst(rd_rst), .rd_tx(rd_tx), .sh_rst(sh_rst), .sh_tx(sh_tx),
        .samp_rst(samp_rst), .samp_sig(samp_sig), .col_first(col_first), .col_last(col_last)
    );

    // Reference model state, derived from the requirements
    int m_run, m_l, m_row;
    int s_len, s_first, s_h, s_expo, s_cf, s_cl;
    int s_t [10];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic snap();
        s_len   = int'(c_len);
        s_first = int'(c_first);
        s_h     = (c_last < c_first) ? 1 : int'(c_last) - int'(c_first) + 1;
        s_expo  = int'(c_expo);
        s_cf    = int'(c_cf);
        s_cl    = int'(c_cl);
        s_t = '{int'(t_sel_on), int'(t_rst_on), int'(t_rst_off), int'(t_srst), int'(t_tx_on),
                int'(t_tx_off), int'(t_ssig), int'(t_sel_off), int'(t_sh_on), int'(t_sh_off)};
    endtask

    task automatic model_clear();
        m_run = 0; m_l = 0; m_row = 0;
        s_len = 0; s_first = 0; s_h = 1; s_expo = 0; s_cf = 0; s_cl = 0;
        for (int i = 0; i < 10; i++) s_t[i] = 0;
    endtask

    task automatic model_adv();
        if (rst) model_clear();
        else if (m_run == 0) begin
            if (start) begin m_run = 1; m_l = 0; m_row = 0; snap(); end
        end else if (m_l == s_len - 1) begin
            m_l = 0;
            if (m_row == s_h - 1) begin m_row = 0; snap(); end
            else m_row++;
        end else m_l++;
    endtask

    function automatic logic [3:0] lanes(input int on, input int off);
        return (m_run != 0 && m_l >= on && m_l < off) ? 4'hF : 4'h0;
    endfunction

    task automatic compare();
        int e, shr, top, shtop;
        logic [3:0] shv;
        e     = (s_expo > s_h) ? s_h : s_expo;
        shr   = (m_row + e) % s_h;
        top   = s_first + m_row;
        shtop = s_first + shr;
        shv   = (e != 0) ? lanes(s_t[8], s_t[9]) : 4'h0;
        chk("R2", "running", 32'(running), 32'(m_run));
        chk("R3", "line_start", 32'(line_start), 32'(m_run != 0 && m_l == 0));
        chk("R4", "frame_start", 32'(frame_start), 32'(m_run != 0 && m_l == 0 && m_row == 0));
        chk("R4", "rd_grp_top", 32'(rd_grp_top), 32'(top));
        chk("R5", "rd_grp_bot", 32'(rd_grp_bot), 32'(top + 128));
        chk("R6", "sh_grp_top", 32'(sh_grp_top), 32'(shtop));
        chk("R5", "sh_grp_bot", 32'(sh_grp_bot), 32'(shtop + 128));
        chk("R7", "rd_sel", 32'(rd_sel), 32'(lanes(s_t[0], s_t[7])));
        chk("R7", "rd_rst", 32'(rd_rst), 32'(lanes(s_t[1], s_t[2])));
        chk("R7", "rd_tx", 32'(rd_tx), 32'(lanes(s_t[4], s_t[5])));
        chk("R8", "samp_rst", 32'(samp_rst), 32'(m_run != 0 && m_l == s_t[3]));
        chk("R8", "samp_sig", 32'(samp_sig), 32'(m_run != 0 && m_l == s_t[6]));
        chk("R9", "sh_rst", 32'(sh_rst), 32'(shv));
        chk("R9", "sh_tx", 32'(sh_tx), 32'(shv));
        chk("R11", "col_first", 32'(col_first), 32'(s_cf));
        chk("R11", "col_last", 32'(col_last), 32'(s_cl));
    endtask

    // Inputs set now are taken at the coming edge; outputs checked at the next falling edge
    task automatic step();
        model_adv();
        @(negedge clk);
        compare();
    endtask

    task automatic cfg_a();
        c_len = 20; c_first = 3; c_last = 6; c_expo = 2; c_cf = 16; c_cl = 500;
        t_sel_on = 1; t_rst_on = 2; t_rst_off = 4; t_srst = 5; t_tx_on = 7;
        t_tx_off = 9; t_ssig = 11; t_sel_off = 13; t_sh_on = 14; t_sh_off = 16;
    endtask

    task automatic cfg_b();
        c_len = 12; c_first = 10; c_last = 12; c_expo = 9; c_cf = 100; c_cl = 900;
        t_sel_on = 1; t_rst_on = 2; t_rst_off = 3; t_srst = 4; t_tx_on = 5;
        t_tx_off = 6; t_ssig = 7; t_sel_off = 9; t_sh_on = 9; t_sh_off = 11;
    endtask

    task automatic run_to_frame(input int limit);
        for (int i = 0; i < limit; i++) begin
            step();
            if (frame_start) break;
        end
    endtask

    task automatic sc_reset();
        model_clear();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk("R1", "running after reset", 32'(running), 0);
        chk("R1", "strobes after reset", 32'({rd_sel, rd_rst, rd_tx, sh_rst, sh_tx}), 0);
        chk("R1", "markers after reset", 32'({line_start, frame_start, samp_rst, samp_sig}), 0);
        chk("R1", "columns after reset", 32'({col_first, col_last}), 0);
    endtask

    task automatic sc_basic();
        cfg_a();
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R2", "frame_start after start", 32'(frame_start), 1);
        chk("R2", "first group after start", 32'(rd_grp_top), 3);
        for (int i = 0; i < 170; i++) step();
    endtask

    task automatic sc_start_ignored();
        logic [GRP_W-1:0] grp_before;
        grp_before = rd_grp_top;
        start = 1'b1;
        step();
        start = 1'b0;
        chk("R2", "no frame_start on start while running", 32'(frame_start), 32'(m_l == 0 && m_row == 0));
        chk("R2", "read group kept on start while running", 32'(rd_grp_top),
            32'((m_l == 0) ? s_first + m_row : int'(grp_before)));
        for (int i = 0; i < 30; i++) step();
    endtask

    task automatic sc_cfg_change();
        cfg_b();
        step();
        chk("R10", "col_first held mid-frame", 32'(col_first), 16);
        chk("R10", "line length held mid-frame", 32'(line_start), 32'(m_l == 0));
        run_to_frame(200);
        chk("R10", "col_first at new frame", 32'(col_first), 100);
        chk("R10", "window at new frame", 32'(rd_grp_top), 10);
        chk("R6", "clamped lead puts shutter on read group", 32'(sh_grp_top), 10);
        for (int i = 0; i < 40; i++) step();
    endtask

    task automatic sc_expo_zero();
        int hits;
        c_expo = 0;
        run_to_frame(200);
        hits = 0;
        for (int i = 0; i < 36; i++) begin
            step();
            if (sh_tx != '0 || sh_rst != '0) hits++;
        end
        chk("R9", "shutter strobes with zero lead", 32'(hits), 0);
    endtask

    task automatic sc_inverted();
        int frames;
        c_first = 20; c_last = 5; c_expo = 3;
        run_to_frame(200);
        run_to_frame(200);
        frames = 0;
        for (int i = 0; i < 36; i++) begin
            step();
            if (line_start) begin
                frames++;
                chk("R12", "frame_start on every line", 32'(frame_start), 1);
                chk("R12", "single group", 32'(rd_grp_top), 20);
            end
        end
        chk("R12", "lines seen", 32'(frames), 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tot++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        sc_reset();
        sc_basic();
        sc_start_ignored();
        sc_cfg_change();
        sc_expo_zero();
        sc_inverted();
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule